// File: doc/BRIEF.md
# Dual comparator control and result register

This block is one byte-wide control and status register for two on-chip comparators. Software reaches it over a simple register bus that decodes a single address. For each comparator the register holds an enable bit and a pin-route bit. It also shows a read-only result bit that follows the comparator's raw output. Two spare bits act as free software flags. The raw comparator outputs come from analog circuits that do not run on the bus clock. They pass through a synchronizer before anything uses them.

Each comparator runs a small settling state machine with three states. `ST_OFF` means the comparator is disabled. `ST_SETTLE` is the first cycle after enabling, when the result is still forced to zero. `ST_LIVE` means the result follows the synchronized input. The machine has these transitions:

- OFF→SETTLE when the enable is written to one.
- SETTLE→LIVE on the next edge while the enable stays set.
- SETTLE→OFF or LIVE→OFF when the enable is cleared.
- OFF→OFF, SETTLE→SETTLE is impossible, and LIVE→LIVE holds otherwise.

When a comparator is both enabled and routed to its pin, it takes over that pin. The pin is then driven as an output carrying the result, whatever the port logic requests.

Top module: `cmp_ctl_reg`

## Requirements
- R1: After reset every register bit reads 0 and both pins follow `port_dir`/`port_dout`.
- R2: Control bits sit at fixed positions: bit 1 enable A, bit 3 route A, bit 4 enable B, bit 6 route B. A write stores them and a read returns them.
- R3: Bit 2 (result A) and bit 5 (result B) are read-only. Values written there are discarded.
- R4: A result bit reads 0 whenever its enable bit is 0, whatever the raw input.
- R5: On the cycle after the edge that sets an enable, its result still reads 0. From the following cycle it follows the synchronized input.
- R6: A raw input change reaches the result bit after two clock edges, through a two-stage synchronizer.
- R7: A pin is driven by its comparator (output enabled, value = result bit) only when both the enable and the route bits of that comparator are 1.
- R8: While a pin is routed, the values of `port_dir` and `port_dout` for that pin have no effect on it.
- R9: The edge that clears an enable also forces its result to 0 and returns the pin to port control.
- R10: Accesses take effect only when `bus_sel` is 1 and `bus_addr` equals `REG_ADDR`. Other writes are ignored, and other reads return 0.
- R11: Bit 0 and bit 7 are spare flags that store and return whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not addressed |
| cmp_raw | input | 2 | Raw comparator outputs, asynchronous |
| port_dir | input | 2 | Port logic direction for the two pins (1 = output) |
| port_dout | input | 2 | Port logic data for the two pins |
| pin_oe | output | 2 | Final pin output enable |
| pin_out | output | 2 | Final pin data |

## Verification
Several rules are checked by assertions on every cycle:

- A disabled comparator never shows a result.
- The first cycle after an enable rises always reads zero.
- A routed pin always carries the result with its driver on.
- A pin that is not routed mirrors the port inputs exactly.
- Clearing an enable drops the result and releases the pin.

Only the bench scenarios can show the rest. These are the two-edge synchronizer latency, the handling of writes to read-only and spare positions, address decoding, and the exact moment the result first follows the input after settling.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int NCMP   = 2;
    localparam int DATA_W = 8;

    // Bits that software can store; result positions (2 and 5) are excluded.
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'b1101_1011;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LIVE   = 2'd2
    } settle_e;

    function automatic int en_bit(input int idx);
        return 1 + 3 * idx;
    endfunction

    function automatic int res_bit(input int idx);
        return 2 + 3 * idx;
    endfunction

    function automatic int route_bit(input int idx);
        return 3 + 3 * idx;
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cmp_settle.sv
module cmp_settle
    import cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic sync_in,
    output logic result
);
    settle_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = en_next ? ST_SETTLE : ST_OFF;
            ST_SETTLE: state_d = en_next ? ST_LIVE   : ST_OFF;
            ST_LIVE:   state_d = en_next ? ST_LIVE   : ST_OFF;
            default:   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_LIVE: result = sync_in;
            default: result = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux (
    input  logic route,
    input  logic result,
    input  logic port_dir,
    input  logic port_dout,
    output logic pin_oe,
    output logic pin_out
);
    always_comb begin
        if (route) begin
            pin_oe  = 1'b1;
            pin_out = result;
        end else begin
            pin_oe  = port_dir;
            pin_out = port_dout;
        end
    end
endmodule

// File: rtl/cmp_ctl_reg.sv
module cmp_ctl_reg
    import cmp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 'h5C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCMP-1:0]   cmp_raw,
    input  logic [NCMP-1:0]   port_dir,
    input  logic [NCMP-1:0]   port_dout,
    output logic [NCMP-1:0]   pin_oe,
    output logic [NCMP-1:0]   pin_out
);
    logic              hit, wr_hit;
    logic [DATA_W-1:0] ctrl_q, ctrl_d, res_vec;
    logic [NCMP-1:0]   en_q, en_d, route_q, result, raw_sync;

    assign hit    = bus_sel && (bus_addr == REG_ADDR);
    assign wr_hit = hit && bus_wr;
    assign ctrl_d = wr_hit ? (bus_wdata & CTRL_MASK) : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    cmp_sync #(.W(NCMP), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (raw_sync)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign en_q[i]    = ctrl_q[en_bit(i)];
        assign en_d[i]    = ctrl_d[en_bit(i)];
        assign route_q[i] = ctrl_q[route_bit(i)] & ctrl_q[en_bit(i)];

        cmp_settle u_settle (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_next (en_d[i]),
            .sync_in (raw_sync[i]),
            .result  (result[i])
        );

        cmp_pin_mux u_pin (
            .route     (route_q[i]),
            .result    (result[i]),
            .port_dir  (port_dir[i]),
            .port_dout (port_dout[i]),
            .pin_oe    (pin_oe[i]),
            .pin_out   (pin_out[i])
        );
    end

    always_comb begin
        res_vec = '0;
        for (int i = 0; i < NCMP; i++) res_vec[res_bit(i)] = result[i];
    end

    assign bus_rdata = hit ? (ctrl_q | res_vec) : '0;
endmodule

// File: rtl/cmp_ctl_chk.sv
module cmp_ctl_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] en_q,
    input logic [N-1:0] route_q,
    input logic [N-1:0] result,
    input logic [N-1:0] port_dir,
    input logic [N-1:0] port_dout,
    input logic [N-1:0] pin_oe,
    input logic [N-1:0] pin_out
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_res_zero_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |-> !result[i]);

        assert_settle_cycle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_q[i]) |-> !result[i]);

        assert_routed_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
            route_q[i] |-> (pin_oe[i] && pin_out[i] == result[i]));

        assert_port_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !route_q[i] |-> (pin_oe[i] == port_dir[i] && pin_out[i] == port_dout[i]));

        assert_clear_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_q[i]) |-> (!result[i] && pin_oe[i] == port_dir[i]));
    end
endmodule

bind cmp_ctl_reg cmp_ctl_chk #(.N(cmp_pkg::NCMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .route_q   (route_q),
    .result    (result),
    .port_dir  (port_dir),
    .port_dout (port_dout),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/sim_cmp_ctl_reg.sv
module sim_cmp_ctl_reg;
    localparam logic [7:0] A = 8'h5C;

    logic       clk = 0, rst_n = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic [1:0] cmp_raw = 0, port_dir = 0, port_dout = 0, pin_oe, pin_out;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    cmp_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_raw(cmp_raw), .port_dir(port_dir), .port_dout(port_dout),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data, input logic sel = 1);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = addr;
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        port_dir = 2'b10; port_dout = 2'b11; cmp_raw = 2'b11;
        cyc(3);
        rd(A, v);
        chk("R1 reset read", v, 8'h00);
        chk("R1 reset pin_oe", {6'd0, pin_oe}, 8'h02);
        chk("R1 reset pin_out", {6'd0, pin_out}, 8'h03);
        chk("R4 disabled results with raw high", v & 8'h24, 8'h00);
    endtask

    task automatic t_flags;
        logic [7:0] v;
        wr(A, 8'h81); rd(A, v);
        chk("R11 spare flags", v, 8'h81);
        wr(A, 8'h00); rd(A, v);
        chk("R11 flags cleared", v, 8'h00);
    endtask

    task automatic t_layout_ro;
        logic [7:0] v;
        cmp_raw = 2'b00; cyc(3);
        wr(A, 8'h24); rd(A, v);
        chk("R3 result positions not writable", v, 8'h00);
        wr(A, 8'h5A); cyc(1); rd(A, v);
        chk("R2 control layout", v, 8'h5A);
        wr(A, 8'h7E); cyc(1); rd(A, v);
        chk("R3 write to result bits discarded", v, 8'h5A);
        wr(A, 8'h00);
    endtask

    task automatic t_settle;
        logic [7:0] v;
        cmp_raw = 2'b11; cyc(3);
        rd(A, v);
        chk("R4 off results zero", v, 8'h00);
        wr(A, 8'h12); rd(A, v);
        chk("R5 settle cycle reads zero", v, 8'h12);
        cyc(1); rd(A, v);
        chk("R5 live after one cycle", v, 8'h36);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        cmp_raw = 2'b00;
        cyc(1); rd(A, v);
        chk("R6 one edge not yet visible", v, 8'h36);
        cyc(1); rd(A, v);
        chk("R6 visible after two edges", v, 8'h12);
        cmp_raw = 2'b10; cyc(2); rd(A, v);
        chk("R6 single input change", v, 8'h32);
        wr(A, 8'h00);
    endtask

    task automatic t_pin;
        logic [7:0] v;
        cmp_raw = 2'b01; port_dir = 2'b00; port_dout = 2'b00; cyc(3);
        wr(A, 8'h0A);
        chk("R7 settle cycle pin drives zero", {6'd0, pin_oe, pin_out}, 8'h04);
        cyc(1); rd(A, v);
        chk("R7 routed result read", v, 8'h0E);
        chk("R8 routed pin overrides port", {6'd0, pin_oe, pin_out}, 8'h05);
        port_dir = 2'b10; port_dout = 2'b10;
        wr(A, 8'h4A); cyc(1);
        chk("R7 route without enable stays port", {6'd0, pin_oe, pin_out}, 8'h0F);
        port_dir = 2'b11; port_dout = 2'b00; #1;
        chk("R8 port data ignored on routed pin", {6'd0, pin_oe, pin_out}, 8'h0D);
        port_dir = 2'b10; port_dout = 2'b10;
    endtask

    task automatic t_clear;
        logic [7:0] v;
        wr(A, 8'h48); rd(A, v);
        chk("R9 result cleared at write edge", v, 8'h48);
        chk("R9 pin released", {6'd0, pin_oe, pin_out}, 8'h0A);
        wr(A, 8'h00);
    endtask

    task automatic t_addr;
        logic [7:0] v;
        wr(A, 8'h81);
        wr(8'h5D, 8'h00); rd(A, v);
        chk("R10 other address write ignored", v, 8'h81);
        wr(A, 8'h00, 1'b0); rd(A, v);
        chk("R10 unselected write ignored", v, 8'h81);
        rd(8'h00, v);
        chk("R10 other address read zero", v, 8'h00);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1;
        t_reset();
        t_flags();
        t_layout_ro();
        t_settle();
        t_sync();
        t_pin();
        t_clear();
        t_addr();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule